// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block lets a host reach the management registers of a serial-link PHY over a two-wire management interface. The host sees two 32-bit registers on a simple register bus. A control register sets the management clock rate and whether a preamble is sent, and it reports completion through a sticky flag. A data register holds the fields of one frame. Writing the data register with its start bit set sends one write or read frame on the line. For a read, the 16 bits returned by the PHY come back in the low half of the same register.

The address fields can be packed two ways, and the `legacy_i` input selects which one is used. Selecting a PHY behind a block-select register is an ordinary write frame: device 0, register 0x1F, with the PHY number in data bits 4 and up. The host polls the done flag, reads the result, and clears the control register when it has finished.

Top module: `mdio_reg_master`

## Requirements
- R1: After reset, both registers read 0, `mdc_o` is low and `mdio_oe_o` is low.
- R2: The control register is at offset 0x128. Bits 6:0 hold the divisor, bit 7 enables the preamble, and bit 8 is the done flag, which reads back but cannot be written. The data register is at offset 0x12C and reads back the value last accepted. Any other offset reads 0.
- R3: Each MDC half period lasts max(divisor,1)+1 system clocks, so one full period is twice that. In idle, MDC is low and the output enable is off.
- R4: With bit 7 set, 32 ones are driven before the frame. With bit 7 clear, no preamble is sent.
- R5: Frame bits are sent MSB first in this order:
  - start 01;
  - opcode, which is 10 when data bit 29 is set (read) and 01 otherwise (write, bit 28);
  - 5-bit PHY address;
  - 5-bit register address;
  - 2 turnaround bits;
  - 16 data bits.
- R6: With `legacy_i`=0, the register address is taken from bits 22:18 and the PHY address from bits 27:23.
- R7: With `legacy_i`=1, the PHY address is taken from bits 27:22, of which the low five bits 26:22 are sent. The register address is taken from bits 21:18 and sent with a leading zero.
- R8: For a write, the master drives the turnaround as 1 then 0 and keeps the output enable on for the whole frame. For a read, the output enable is off during the turnaround and the data bits. The data is sampled on rising MDC edges and placed in data bits 15:0 when the frame completes. A write leaves bits 15:0 as written.
- R9: The done flag clears on the clock edge that starts a frame. It sets on the falling MDC edge that ends the last bit, at the same moment the master goes idle. The line changes only while MDC is low.
- R10: While a frame is in progress, any write to the data register is ignored. The frame on the line and the stored register value are unchanged, and no second frame follows.
- R11: A data-register write with bit 30 clear is stored but sends nothing and leaves the done flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus write strobe qualifier |
| we_i | input | 1 | Write enable |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| legacy_i | input | 1 | Selects the legacy address-field layout |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data in |

## Verification
The main sweep covers 32 frames: every combination of divisors 0 to 3, preamble on and off, the two layouts and the two opcodes. Each frame carries different address and data values. Divisor 0 against 1 shows the clamp to 1. Preamble on against off shows the 64-bit and 32-bit frame lengths. The two layouts are told apart by a PHY address with bit 5 set, which legacy mode must drop, and by register addresses whose fifth bit legacy mode must zero. The opcodes are told apart by the output-enable pattern and by where bits 15:0 come from. Further runs cover:
- the largest divisor;
- a block-select write to device 0, register 0x1F;
- a start written in the middle of a frame;
- a data write without the start bit.

// File: rtl/mdio_reg_pkg.sv
package mdio_reg_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned DATA_BITS  = 16;
  localparam int unsigned TA_BITS    = 2;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned START_BIT  = 30;
  localparam int unsigned RD_BIT     = 29;
  localparam int unsigned ADDR_LSB   = 18;  // address fields occupy bits 27:18
  localparam int unsigned ADDR_FLD_W = 10;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } op_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input op_e op, input logic [4:0] phy, input logic [4:0] rg, input logic [DATA_BITS-1:0] wd);
    logic [TA_BITS-1:0] ta;
    ta = (op == OP_READ) ? 2'b11 : 2'b10;
    return {2'b01, op, phy, rg, ta, wd};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] half, cnt_q;
  logic             mdc_q, wrap;

  // divisor 0 behaves as 1
  assign half   = (div_i == '0) ? CNT_W'(2) : CNT_W'(div_i) + CNT_W'(1);
  assign wrap   = run_i && (cnt_q >= half - CNT_W'(1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_field_decode.sv
module mdio_field_decode
  import mdio_reg_pkg::*;
(
  input  logic                  rd_i,
  input  logic [ADDR_FLD_W-1:0] fld_i,    // data bits 27:18
  input  logic                  legacy_i,
  output logic [4:0]            phy_o,
  output logic [4:0]            reg_o,
  output op_e                   op_o
);
  always_comb begin
    if (legacy_i) begin
      phy_o = fld_i[8:4];             // bits 26:22, bit 27 dropped
      reg_o = {1'b0, fld_i[3:0]};     // bits 21:18
    end else begin
      phy_o = fld_i[9:5];             // bits 27:23
      reg_o = fld_i[4:0];             // bits 22:18
    end
    op_o = rd_i ? OP_READ : OP_WRITE;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_reg_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  pre_en_i,
  input  logic                  is_read_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  mdio_i,
  output logic                  busy_o,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  output logic                  done_o,
  output logic                  rx_valid_o,
  output logic [DATA_BITS-1:0]  rx_data_o
);
  localparam int unsigned TOT   = PRE_BITS + FRAME_BITS;
  localparam int unsigned CNT_W = $clog2(TOT + 1);

  logic [TOT-1:0]       sh_q;
  logic [CNT_W-1:0]     left_q;
  logic                 busy_q, rd_q, last;
  logic [DATA_BITS-1:0] rx_q;

  assign last = busy_q && fall_i && (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= is_read_i;
      sh_q   <= pre_en_i ? {{PRE_BITS{1'b1}}, frame_i} : {frame_i, {PRE_BITS{1'b0}}};
      left_q <= pre_en_i ? CNT_W'(TOT) : CNT_W'(FRAME_BITS);
    end else if (busy_q) begin
      if (rise_i && rd_q) rx_q <= {rx_q[DATA_BITS-2:0], mdio_i};
      if (fall_i) begin
        sh_q   <= sh_q << 1;
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  // released for read turnaround and read data
  assign mdio_oe_o  = busy_q && !(rd_q && (left_q <= CNT_W'(TA_BITS + DATA_BITS)));
  assign mdio_o     = busy_q && sh_q[TOT-1];
  assign busy_o     = busy_q;
  assign done_o     = last;
  assign rx_valid_o = last && rd_q;
  assign rx_data_o  = rx_q;
endmodule

// File: rtl/mdio_reg_master.sv
module mdio_reg_master
  import mdio_reg_pkg::*;
#(
  parameter int unsigned           ADDR_W   = 12,
  parameter int unsigned           DIV_W    = 7,
  parameter logic [ADDR_W-1:0]     CTRL_OFS = 'h128,
  parameter logic [ADDR_W-1:0]     DATA_OFS = 'h12C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              legacy_i,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic [DIV_W-1:0]     div_q;
  logic                 pre_q, done_q;
  logic [REG_W-1:0]     data_q;
  logic                 wr_ctrl, wr_data, launch, busy;
  logic                 rise, fall, eng_done, rx_valid;
  logic [DATA_BITS-1:0] rx_data;
  logic [4:0]           phy, rg;
  op_e                  op;

  assign wr_ctrl = req_i && we_i && (addr_i == CTRL_OFS);
  assign wr_data = req_i && we_i && (addr_i == DATA_OFS) && !busy;
  assign launch  = wr_data && wdata_i[START_BIT];

  mdio_field_decode u_dec (
    .rd_i     (wdata_i[RD_BIT]),
    .fld_i    (wdata_i[ADDR_LSB +: ADDR_FLD_W]),
    .legacy_i (legacy_i),
    .phy_o    (phy),
    .reg_o    (rg),
    .op_o     (op)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (launch),
    .pre_en_i   (pre_q),
    .is_read_i  (op == OP_READ),
    .frame_i    (build_frame(op, phy, rg, wdata_i[DATA_BITS-1:0])),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdio_i     (mdio_i),
    .busy_o     (busy),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .done_o     (eng_done),
    .rx_valid_o (rx_valid),
    .rx_data_o  (rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      pre_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) begin
        div_q <= wdata_i[DIV_W-1:0];
        pre_q <= wdata_i[DIV_W];
      end
      if (wr_data) data_q <= wdata_i;
      else if (rx_valid) data_q[DATA_BITS-1:0] <= rx_data;
      if (launch) done_q <= 1'b0;
      else if (eng_done) done_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFS) rdata_o = REG_W'({done_q, pre_q, div_q});
    else if (addr_i == DATA_OFS) rdata_o = data_q;
  end
endmodule

// File: rtl/mdio_reg_master_chk.sv
module mdio_reg_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        done_i,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        oe_i,
  input logic [15:0] data_hi_i
);
  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !oe_i));

  assert_line_stable_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> ($stable(mdio_i) && $stable(oe_i)));

  assert_done_at_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $fell(busy_i));

  assert_done_only_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  assert_reg_hold_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(data_hi_i));
endmodule

bind mdio_reg_master mdio_reg_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy),
  .done_i    (done_q),
  .mdc_i     (mdc_o),
  .mdio_i    (mdio_o),
  .oe_i      (mdio_oe_o),
  .data_hi_i (data_q[31:16])
);

// File: tb/mdio_reg_master_tb.sv
`timescale 1ns/1ps
module mdio_reg_master_tb;
  localparam logic [11:0] CTRL = 12'h128;
  localparam logic [11:0] DATA = 12'h12C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, legacy = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, mdo, moe, mdi, phy_bit = 1'b1;

  int n_chk = 0, n_fail = 0;
  int nrise = 0, per_err = 0, exp_period = 0, pre_len = 0, cyc = 0, last_cyc = 0;
  logic [63:0] cap_b, cap_o;
  logic [15:0] phy_word = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  assign mdi = moe ? mdo : phy_bit;

  mdio_reg_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .legacy_i(legacy),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi)
  );

  always @(posedge mdc) begin
    #1;
    if (nrise < 64) begin
      cap_b[nrise] = mdo;
      cap_o[nrise] = moe;
    end
    if (nrise > 0 && (cyc - last_cyc) != exp_period) per_err++;
    last_cyc = cyc;
    nrise++;
  end

  // PHY model drives read data after each falling edge
  always @(negedge mdc) begin
    int j;
    j = nrise - pre_len - 16;
    if (j >= 0 && j < 16) phy_bit = phy_word[15-j];
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      bus_read(CTRL, v);
      if (v[8]) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  function automatic logic [31:0] mk_frame(input bit rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  function automatic logic [31:0] cap_frame(input int plen, input bit oe_sel);
    logic [31:0] f;
    for (int i = 0; i < 32; i++) f[31-i] = oe_sel ? cap_o[plen+i] : cap_b[plen+i];
    return f;
  endfunction

  function automatic logic [31:0] mk_word(input bit rd, input bit leg, input logic [5:0] dev, input logic [4:0] rg, input logic [15:0] wd);
    logic [31:0] w;
    w = 32'h4002_0000 | (rd ? 32'h2000_0000 : 32'h1000_0000) | {16'd0, wd};
    if (leg) w = w | ({26'd0, dev} << 22) | ({28'd0, rg[3:0]} << 18);
    else     w = w | ({27'd0, dev[4:0]} << 23) | ({27'd0, rg} << 18);
    return w;
  endfunction

  task automatic arm(input int div, input bit pre, input logic [15:0] pw);
    nrise = 0; per_err = 0; phy_word = pw; phy_bit = 1'b1;
    pre_len = pre ? 32 : 0;
    exp_period = 2 * ((div == 0 ? 1 : div) + 1);
  endtask

  task automatic run_txn(input int div, input bit pre, input bit leg, input bit rd,
                         input logic [5:0] dev, input logic [4:0] rg, input logic [15:0] wd, input logic [15:0] pw);
    logic [31:0] w, v, ef, af, mask;
    logic [4:0]  ep, er;
    bit ok;
    int plen;
    plen = pre ? 32 : 0;
    ep = dev[4:0];
    er = leg ? {1'b0, rg[3:0]} : rg;
    w = mk_word(rd, leg, dev, rg, wd);
    bus_write(CTRL, {24'd0, pre, 7'(div)});
    legacy = leg;
    arm(div, pre, pw);
    bus_write(DATA, w);
    bus_read(CTRL, v);
    chk(v[8] == 1'b0, "R9 done clears on start", v, 0);
    wait_done(ok);
    chk(ok, "R9 done sets at end", 64'(ok), 1);
    chk(nrise == 32 + plen, "R4 frame length", 64'(nrise), 64'(32 + plen));
    ok = 1'b1;
    for (int i = 0; i < plen; i++) if (!cap_b[i] || !cap_o[i]) ok = 1'b0;
    chk(ok, "R4 preamble ones", cap_b, 64'hFFFF_FFFF_FFFF_FFFF);
    mask = rd ? 32'hFFFC_0000 : 32'hFFFF_FFFF;
    ef = mk_frame(rd, ep, er, wd);
    af = cap_frame(plen, 1'b0);
    chk((af & mask) == (ef & mask), leg ? "R5 R7 legacy frame bits" : "R5 R6 current frame bits", af, ef);
    af = cap_frame(plen, 1'b1);
    chk(af == mask, "R8 output enable pattern", af, mask);
    chk(per_err == 0, "R3 mdc period", 64'(per_err), 0);
    bus_read(DATA, v);
    chk(v[15:0] == (rd ? pw : wd), "R8 data low half", v, rd ? pw : wd);
    chk(v[31:16] == w[31:16], "R2 data upper readback", v, w);
    chk(!mdc && !moe, "R3 idle line", {mdc, moe}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, w1, w2, af, ef;
    bit ok;
    repeat (3) @(negedge clk);
    bus_read(CTRL, v); chk(v == 0, "R1 ctrl reset", v, 0);
    bus_read(DATA, v); chk(v == 0, "R1 data reset", v, 0);
    chk(!mdc && !moe, "R1 line idle", {mdc, moe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(CTRL, v); chk(v == 0, "R1 ctrl after release", v, 0);

    bus_write(CTRL, 32'hFFFF_FFFF);
    bus_read(CTRL, v); chk(v == 32'h0000_00FF, "R2 ctrl fields, done read-only", v, 32'hFF);
    bus_read(12'h130, v); chk(v == 0, "R2 unmapped offset", v, 0);
    bus_write(CTRL, 0);

    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 2; p++)
        for (int l = 0; l < 2; l++)
          for (int r = 0; r < 2; r++)
            run_txn(d, p[0], l[0], r[0],
                    6'(32 | (7 * d + 3 * p + 2 * l + r + 1)),
                    5'(16 | (5 * d + p + 4 * l + 2 * r)),
                    16'(16'hA5C3 ^ (d * 16'h1111) ^ (p * 16'h0F0F) ^ (l * 16'h8001) ^ (r * 16'h4242)),
                    16'(16'h1234 + d * 16'h0321 + p * 16'h5000 + l * 16'h0808 + r * 16'h0013));

    run_txn(127, 1'b0, 1'b0, 1'b1, 6'h15, 5'h0A, 16'h0000, 16'hC0DE);  // R3 largest divisor
    run_txn(2, 1'b1, 1'b0, 1'b0, 6'h00, 5'h1F, 16'h0050, 16'h0000);    // block select, PHY 5

    // R10: start during a frame is ignored
    w1 = mk_word(1'b0, 1'b0, 6'h03, 5'h09, 16'h1357);
    w2 = mk_word(1'b1, 1'b0, 6'h1C, 5'h02, 16'hFFFF);
    bus_write(CTRL, 32'h0000_0001);
    legacy = 1'b0;
    arm(1, 1'b0, 16'hFFFF);
    bus_write(DATA, w1);
    repeat (20) @(negedge clk);
    bus_write(DATA, w2);
    wait_done(ok);
    chk(ok, "R10 original frame completes", 64'(ok), 1);
    af = cap_frame(0, 1'b0);
    ef = mk_frame(1'b0, 5'h03, 5'h09, 16'h1357);
    chk(nrise == 32 && af == ef, "R10 frame unaffected", {32'(nrise), af}, {32'd32, ef});
    bus_read(DATA, v); chk(v == w1, "R10 register unchanged", v, w1);
    repeat (200) @(negedge clk);
    chk(nrise == 32 && !mdc, "R10 no second frame", 64'(nrise), 32);

    // R11: write without start
    arm(1, 1'b0, 16'h0);
    bus_write(DATA, 32'h0123_4567);
    repeat (100) @(negedge clk);
    chk(nrise == 0 && !moe, "R11 nothing sent", 64'(nrise), 0);
    bus_read(DATA, v); chk(v == 32'h0123_4567, "R11 value stored", v, 32'h0123_4567);
    bus_read(CTRL, v); chk(v[8] == 1'b1, "R11 done unchanged", v, 32'h101);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule